// File: doc/BRIEF.md
# Coarse Delay Ramp Controller

This block drives the 8-bit coarse code of a clock delay line from a target value that the host writes. A sudden jump in the coarse code can glitch the delayed clock, so the block can instead walk the code toward a new target in small steps, paced by a tick that comes once every 256 clock cycles. Two step sizes are available: one code per tick, or four codes per tick. When four codes would pass the target, the last step is shortened so that the code lands on the target exactly.

With ramping turned off, the block applies a written target in one step at the next boundary of a 1024-cycle divider, so the new code appears no later than 1024 cycles after the write. A busy flag is high while the coarse code has not yet reached the target. The fine delay byte and the clock invert bit are not handled here; they pass from input to output unchanged.

Top module: `coarse_delay_ramp`

## Requirements
- R1: While reset is low and after it is released, the coarse output is 0, the stored target is 0 and busy is 0. A free-running cycle counter restarts from 0, so the 256-cycle tick edges are the 256th, 512th, ... rising edges after reset release.
- R2: The target is stored only on a clock edge where `tgt_wr` is 1. A change of `tgt_coarse` without the strobe leaves the output and busy unchanged.
- R3: With `ramp_en` = 1 and `ramp_fast` = 0, the coarse output moves by exactly one code toward the stored target at each 256-cycle tick edge where it differs from the target, and changes at no other edge.
- R4: With `ramp_en` = 1 and `ramp_fast` = 1, the output moves by four codes toward the target at each tick edge; when fewer than four codes remain, it moves by the remainder and lands on the target without overshoot.
- R5: Once the output equals the target it holds its value until a new target is written.
- R6: A target written during a ramp is used from the next tick edge on, and the step direction is taken from the current output compared to the new target.
- R7: With `ramp_en` = 0, the output takes the stored target in a single step at the next 1024-cycle edge (the 1024th, 2048th, ... edge after reset release), no later than 1024 cycles after the write, and does not change at other edges.
- R8: `busy` is 1 exactly when the coarse output differs from the stored target.
- R9: `fine_out` equals `fine_in` and `inv_out` equals `inv_in` at all times, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_coarse | input | 8 | Coarse delay target value |
| tgt_wr | input | 1 | Strobe that stores `tgt_coarse` as the target |
| fine_in | input | 8 | Fine delay byte |
| inv_in | input | 1 | Clock invert bit |
| ramp_en | input | 1 | 1: ramp toward the target; 0: direct update |
| ramp_fast | input | 1 | Ramp step: 0 = one code, 1 = four codes per tick |
| coarse_out | output | 8 | Current coarse delay code |
| fine_out | output | 8 | Fine delay byte to the delay line |
| inv_out | output | 1 | Clock invert bit to the delay line |
| busy | output | 1 | Output has not yet reached the target |

## Verification
A target write is stored at the edge after the strobe is driven, and the coarse output then changes only at tick edges, so every ramp result is due at the first, second or nth multiple of 256 edges counted from reset release. The bench keeps its own count of edges since reset, issues each write just after a tick edge, and samples at the falling edge that follows the tick edge it is waiting for. Direct updates are due at multiples of 1024 edges; the bench checks the old value three ticks after a write placed right after such an edge and the new value one tick later. Busy and the pass-through outputs are sampled at falling edges in the same way.

// File: rtl/coarse_delay_ramp.sv
module coarse_delay_ramp #(
  parameter int CODE_W    = 8,
  parameter int FINE_W    = 8,
  parameter int TICK_W    = 8,
  parameter int DIV_W     = 10,
  parameter int FAST_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] tgt_coarse,
  input  logic              tgt_wr,
  input  logic [FINE_W-1:0] fine_in,
  input  logic              inv_in,
  input  logic              ramp_en,
  input  logic              ramp_fast,
  output logic [CODE_W-1:0] coarse_out,
  output logic [FINE_W-1:0] fine_out,
  output logic              inv_out,
  output logic              busy
);

  localparam logic [CODE_W-1:0] STEP_SLOW = CODE_W'(1);
  localparam logic [CODE_W-1:0] STEP_FAST = CODE_W'(FAST_STEP);

  logic [DIV_W-1:0]  cnt_q;
  logic [CODE_W-1:0] tgt_q;
  logic [CODE_W-1:0] cur_q;
  logic [CODE_W-1:0] cur_d;
  logic [CODE_W-1:0] gap;
  logic [CODE_W-1:0] stride;
  logic [CODE_W-1:0] mv;
  logic              up;
  logic              tick;
  logic              dtick;

  assign tick   = &cnt_q[TICK_W-1:0];
  assign dtick  = &cnt_q;
  assign up     = tgt_q > cur_q;
  assign gap    = up ? (tgt_q - cur_q) : (cur_q - tgt_q);
  assign stride = ramp_fast ? STEP_FAST : STEP_SLOW;
  assign mv     = (gap < stride) ? gap : stride;

  always_comb begin
    cur_d = cur_q;
    if (ramp_en) begin
      if (tick && busy) cur_d = up ? (cur_q + mv) : (cur_q - mv);
    end else if (dtick) begin
      cur_d = tgt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tgt_q <= '0;
      cur_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      cur_q <= cur_d;
      if (tgt_wr) tgt_q <= tgt_coarse;
    end
  end

  assign coarse_out = cur_q;
  assign busy       = cur_q != tgt_q;
  assign fine_out   = fine_in;
  assign inv_out    = inv_in;

  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (coarse_out == '0 && !busy)); // R1
  AST_NO_MOVE_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(coarse_out)); // R3
  AST_SLOW_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ramp_en && !ramp_fast && busy) |=>
    ((coarse_out - $past(coarse_out) == CODE_W'(1)) || ($past(coarse_out) - coarse_out == CODE_W'(1)))); // R3
  AST_FAST_NO_OVERSHOOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ramp_en && busy && coarse_out < tgt_q) |=>
    (coarse_out > $past(coarse_out) && coarse_out <= $past(tgt_q))); // R4
  AST_FAST_NO_OVERSHOOT_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ramp_en && busy && coarse_out > tgt_q) |=>
    (coarse_out < $past(coarse_out) && coarse_out >= $past(tgt_q))); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tgt_wr) |=> ($stable(coarse_out) && !busy)); // R5
  AST_DIRECT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dtick && !ramp_en) |=> (coarse_out == $past(tgt_q))); // R7
  AST_PASS_THROUGH: assert property (@(posedge clk)
    (fine_out == fine_in && inv_out == inv_in)); // R9

endmodule

// File: tb/coarse_delay_ramp_bench.sv
module coarse_delay_ramp_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tgt_coarse = '0;
  logic       tgt_wr = 1'b0;
  logic [7:0] fine_in = '0;
  logic       inv_in = 1'b0;
  logic       ramp_en = 1'b0;
  logic       ramp_fast = 1'b0;
  logic [7:0] coarse_out;
  logic [7:0] fine_out;
  logic       inv_out;
  logic       busy;

  int total = 0;
  int bad = 0;
  int ecount = 0;

  coarse_delay_ramp u_coarse_delay_ramp (
    .clk(clk), .rst_n(rst_n), .tgt_coarse(tgt_coarse), .tgt_wr(tgt_wr),
    .fine_in(fine_in), .inv_in(inv_in), .ramp_en(ramp_en), .ramp_fast(ramp_fast),
    .coarse_out(coarse_out), .fine_out(fine_out), .inv_out(inv_out), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  // {wr, ramp_en, fast, target, ticks, expected output, expected busy}
  typedef struct packed {
    logic       wr;
    logic       en;
    logic       fast;
    logic [7:0] tgt;
    logic [3:0] ticks;
    logic [7:0] exp;
    logic       exp_busy;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b0, 8'd3,   4'd1, 8'd1,   1'b1},  // R3 slow up
    '{1'b0, 1'b1, 1'b0, 8'd3,   4'd2, 8'd3,   1'b0},  // R3 reaches
    '{1'b0, 1'b1, 1'b0, 8'd3,   4'd1, 8'd3,   1'b0},  // R5 holds
    '{1'b1, 1'b1, 1'b1, 8'd13,  4'd1, 8'd7,   1'b1},  // R4 fast up
    '{1'b0, 1'b1, 1'b1, 8'd13,  4'd2, 8'd13,  1'b0},  // R4 clipped step
    '{1'b1, 1'b1, 1'b1, 8'd5,   4'd1, 8'd9,   1'b1},  // R6 reverse
    '{1'b1, 1'b1, 1'b0, 8'd12,  4'd1, 8'd10,  1'b1},  // R6 retarget mid-ramp
    '{1'b1, 1'b1, 1'b1, 8'd0,   4'd3, 8'd0,   1'b0},  // R4 down with clip
    '{1'b1, 1'b1, 1'b1, 8'd255, 4'd1, 8'd4,   1'b1},  // R8 busy while ramping
    '{1'b1, 1'b0, 1'b0, 8'd200, 4'd4, 8'd200, 1'b0},  // R7 direct jump
    '{1'b1, 1'b0, 1'b1, 8'd0,   4'd4, 8'd0,   1'b0},  // R7 direct down
    '{1'b1, 1'b1, 1'b1, 8'd2,   4'd1, 8'd2,   1'b0},  // R4 short clip
    '{1'b1, 1'b1, 1'b0, 8'd0,   4'd2, 8'd0,   1'b0},  // R3 slow down
    '{1'b1, 1'b0, 1'b0, 8'd253, 4'd4, 8'd253, 1'b0},  // R7 direct
    '{1'b1, 1'b1, 1'b1, 8'd255, 4'd1, 8'd255, 1'b0},  // R4 top clip
    '{1'b1, 1'b1, 1'b1, 8'd0,   4'd1, 8'd251, 1'b1}   // R4 down from top
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      do begin
        @(posedge clk);
        #1;
      end while (ecount % period != 0);
    end
    @(negedge clk);
  endtask

  task automatic write_tgt(input logic [7:0] v);
    tgt_coarse = v;
    tgt_wr = 1'b1;
    @(negedge clk);
    tgt_wr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 coarse in reset", coarse_out, 0);
    chk("R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 coarse after reset", coarse_out, 0);

    fine_in = 8'hA5; inv_in = 1'b1;
    #1;
    chk("R9 fine pass", fine_out, 8'hA5);
    chk("R9 inv pass", inv_out, 1);
    fine_in = 8'h3C; inv_in = 1'b0;
    #1;
    chk("R9 fine pass 2", fine_out, 8'h3C);
    chk("R9 inv pass 2", inv_out, 0);

    // vector table: each write lands just after a tick edge
    for (int v = 0; v < NV; v++) begin
      ramp_en = VECS[v].en;
      ramp_fast = VECS[v].fast;
      if (VECS[v].wr) write_tgt(VECS[v].tgt);
      wait_ticks(int'(VECS[v].ticks), 256);
      chk($sformatf("R3/R4/R5/R6/R7 vec%0d coarse", v), coarse_out, VECS[v].exp);
      chk($sformatf("R8 vec%0d busy", v), busy, VECS[v].exp_busy);
    end

    // R2: target input without strobe has no effect
    ramp_en = 1'b1; ramp_fast = 1'b1;
    write_tgt(8'd251);
    wait_ticks(1, 256);
    tgt_coarse = 8'd10;
    wait_ticks(1, 256);
    chk("R2 no strobe coarse", coarse_out, 251);
    chk("R2 no strobe busy", busy, 0);

    // R7: direct latency, write right after a 1024-cycle edge
    ramp_en = 1'b0;
    wait_ticks(1, 1024);
    write_tgt(8'd77);
    wait_ticks(3, 256);
    chk("R7 not yet applied", coarse_out, 251);
    chk("R8 busy pending direct", busy, 1);
    wait_ticks(1, 256);
    chk("R7 applied at 1024 edge", coarse_out, 77);
    chk("R8 busy cleared", busy, 0);

    // R1: reset mid-ramp
    ramp_en = 1'b1; ramp_fast = 1'b0;
    write_tgt(8'd90);
    wait_ticks(1, 256);
    chk("R3 mid-ramp before reset", coarse_out, 78);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears coarse", coarse_out, 0);
    chk("R1 reset clears busy", busy, 0);
    rst_n = 1'b1;
    write_tgt(8'd2);
    wait_ticks(1, 256);
    chk("R1 tick restarts", coarse_out, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule